// File: doc/BRIEF.md
# Status Register Write Protection Unit

This unit keeps the status byte of a serial non-volatile memory and decides, one request at a time, whether a change to that byte or to the memory array may go ahead. The byte carries a busy flag, a write-enable flag, a three-bit protection code and a lock bit. The protection code marks a region at the top of the sector space as read-only. The region is a power-of-two fraction of the sectors, and it doubles with each code step. The lock bit works with an active-low write-protect pin. When both are in force, the status byte cannot be rewritten at all.

A command decoder in front of the unit turns serial traffic into single-cycle requests: set or clear the write-enable flag, write a new status byte, or start a program or erase at a byte address. The unit answers each request one cycle later with a grant or deny pulse. For a program or erase it also flags whether the target lies in the protected region. An engine behind the unit runs granted operations and reports their end on `op_done`, which clears the busy flag. The status byte is presented on `status` every cycle, so it can be read at any time, including while an operation is running.

Top module: `sr_protect_unit`

## Requirements
- R1: `status` shows the register every cycle, including while busy. Bit 0 is busy, bit 1 is write-enable, bits 4:2 are the protection code, bit 7 is the lock bit, and bits 6:5 read 0. Synchronous reset sets the byte and all response outputs to 0.
- R2: `wren_req` sets write-enable and `wrdi_req` clears it when the unit is not busy. While busy, both are ignored.
- R3: The code maps to a count of protected top sectors out of 32: 000 protects none, 001 one, 010 two, 011 four, 100 eight, 101 sixteen, and 110 and 111 protect all. The sector number is address bits 20:16.
- R4: When the lock bit is 1 and `wp_n` is 0, a status write is denied and the byte is unchanged.
- R5: In every other lock and pin combination, a status write is granted exactly when write-enable is 1 and the unit is idle. A grant loads the code from data bits 4:2 and the lock bit from data bit 7, ignores the other data bits, sets busy and clears write-enable. A denied status write changes nothing.
- R6: A bulk erase (`mod_cmd` 10) is refused and flagged protected whenever the code is nonzero.
- R7: A page program (`mod_cmd` 00) or sector erase (01) that targets a protected sector is refused and flagged protected. When the unit is idle, the refusal also clears write-enable.
- R8: An unprotected program or erase is granted when write-enable is 1 and the unit is idle. The grant sets busy and clears write-enable. The request is denied with no state change when write-enable is 0. Code 11 is always denied, is never flagged, and changes nothing.
- R9: While busy, every status write and every program or erase request is denied and leaves write-enable, code and lock unchanged. `op_done` clears busy.
- R10: Each request receives exactly one single-cycle response in the cycle after it is presented, and grant and deny are never high together. At most one of the four requests is presented per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_req | input | 1 | Set write-enable request |
| wrdi_req | input | 1 | Clear write-enable request |
| wrsr_req | input | 1 | Status write request |
| wrsr_data | input | 8 | New status byte for a status write |
| mod_req | input | 1 | Program or erase request |
| mod_cmd | input | 2 | 00 page program, 01 sector erase, 10 bulk erase, 11 reserved |
| mod_addr | input | 21 | Target byte address |
| op_done | input | 1 | Running operation finished |
| status | output | 8 | Status byte |
| wrsr_grant | output | 1 | Status write accepted |
| wrsr_deny | output | 1 | Status write refused |
| mod_grant | output | 1 | Program or erase accepted |
| mod_deny | output | 1 | Program or erase refused |
| mod_protected | output | 1 | Program or erase target lies in the protected region |

## Verification
Several rules are checked by assertions on every clock. These cover the hardware lock refusing status writes, the bulk-erase refusal under any nonzero code, denial of everything while busy, the clearing of write-enable after a grant or a protected refusal, and the exclusivity of the response pulses. The exact region boundary for each code can only be shown by the bench scenarios, which walk every code across the first and last byte of all 32 sectors. The same holds for the full lock and pin truth table and for data bits that must not reach the register. In those scenarios a behavioural model is compared against the outputs on every cycle.

// File: rtl/sr_prot_pkg.sv
package sr_prot_pkg;

  localparam int STATUS_W = 8;
  localparam int CODE_W   = 3;

  typedef enum logic [1:0] {
    CMD_PAGE_PROG  = 2'b00,
    CMD_SECT_ERASE = 2'b01,
    CMD_BULK_ERASE = 2'b10,
    CMD_RESERVED   = 2'b11
  } mod_cmd_e;

  // bit 7 lock, 6:5 zero, 4:2 code, 1 write enable, 0 busy
  typedef struct packed {
    logic              lock;
    logic [1:0]        rsvd;
    logic [CODE_W-1:0] code;
    logic              wel;
    logic              busy;
  } status_t;

endpackage

// File: rtl/sr_region_map.sv
module sr_region_map #(
  parameter int SECT_W = 5,
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code,
  input  logic [SECT_W-1:0] sector,
  output logic              in_region
);

  localparam int NSECT = 1 << SECT_W;
  localparam int NCODE = 1 << CODE_W;
  localparam int SW1   = SECT_W + 1;

  // first protected sector index for a code; NSECT means none
  function automatic logic [SECT_W:0] first_prot(input int c);
    if (c == 0) return SW1'(NSECT);
    if (c - 1 >= SECT_W) return '0;
    return SW1'(NSECT - (1 << (c - 1)));
  endfunction

  logic [SECT_W:0] bound [NCODE];

  genvar gc;
  generate
    for (gc = 0; gc < NCODE; gc++) begin : g_bound
      assign bound[gc] = first_prot(gc);
    end
  endgenerate

  assign in_region = ({1'b0, sector} >= bound[code]);

  always_comb begin
    if (code == '0) begin
      p_code_none_r3: assert (!in_region);
    end
    if (int'(code) > SECT_W) begin
      p_code_all_r3: assert (in_region);
    end
  end

endmodule

// File: rtl/sr_request_eval.sv
module sr_request_eval
  import sr_prot_pkg::*;
(
  input  status_t  st,
  input  logic     wp_n,
  input  logic     wrsr_req,
  input  logic     mod_req,
  input  mod_cmd_e mod_cmd,
  input  logic     in_region,
  output logic     wrsr_ok,
  output logic     mod_ok,
  output logic     mod_hit,
  output logic     drop_wel
);

  logic hw_lock;
  logic target_prot;
  logic cmd_valid;
  logic unused_rsvd;

  assign unused_rsvd = ^st.rsvd;
  assign hw_lock     = st.lock & ~wp_n;
  assign cmd_valid   = (mod_cmd != CMD_RESERVED);

  always_comb begin
    unique case (mod_cmd)
      CMD_BULK_ERASE: target_prot = (st.code != '0);
      CMD_RESERVED:   target_prot = 1'b0;
      default:        target_prot = in_region;
    endcase
  end

  assign wrsr_ok  = wrsr_req & ~st.busy & st.wel & ~hw_lock;
  assign mod_ok   = mod_req & cmd_valid & ~st.busy & st.wel & ~target_prot;
  assign mod_hit  = mod_req & target_prot;
  assign drop_wel = mod_req & ~st.busy & target_prot;

endmodule

// File: rtl/sr_status_core.sv
module sr_status_core
  import sr_prot_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wp_n,
  input  logic                wren_req,
  input  logic                wrdi_req,
  input  logic                wrsr_req,
  input  logic [STATUS_W-1:0] wrsr_data,
  input  logic                mod_req,
  input  mod_cmd_e            mod_cmd,
  input  logic                op_done,
  input  logic                wrsr_ok,
  input  logic                mod_ok,
  input  logic                mod_hit,
  input  logic                drop_wel,
  output status_t             st_q,
  output logic                wrsr_grant_q,
  output logic                wrsr_deny_q,
  output logic                mod_grant_q,
  output logic                mod_deny_q,
  output logic                mod_prot_q
);

  logic unused_data_bits;
  assign unused_data_bits = ^{wrsr_data[6:5], wrsr_data[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= '0;
      wrsr_grant_q <= 1'b0;
      wrsr_deny_q  <= 1'b0;
      mod_grant_q  <= 1'b0;
      mod_deny_q   <= 1'b0;
      mod_prot_q   <= 1'b0;
    end else begin
      wrsr_grant_q <= wrsr_ok;
      wrsr_deny_q  <= wrsr_req & ~wrsr_ok;
      mod_grant_q  <= mod_ok;
      mod_deny_q   <= mod_req & ~mod_ok;
      mod_prot_q   <= mod_hit;
      if (op_done) st_q.busy <= 1'b0;
      if (wrsr_ok) begin
        st_q.code <= wrsr_data[4:2];
        st_q.lock <= wrsr_data[7];
        st_q.wel  <= 1'b0;
        st_q.busy <= 1'b1;
      end else if (mod_ok) begin
        st_q.wel  <= 1'b0;
        st_q.busy <= 1'b1;
      end else if (drop_wel) begin
        st_q.wel  <= 1'b0;
      end else if (wren_req && !st_q.busy) begin
        st_q.wel  <= 1'b1;
      end else if (wrdi_req && !st_q.busy) begin
        st_q.wel  <= 1'b0;
      end
    end
  end

  p_one_req_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wren_req, wrdi_req, wrsr_req, mod_req}));

  p_excl_resp_r10: assert property (@(posedge clk) disable iff (rst)
    !(wrsr_grant_q && wrsr_deny_q) && !(mod_grant_q && mod_deny_q));

  p_hw_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (wrsr_req && st_q.lock && !wp_n) |=> (wrsr_deny_q && !wrsr_grant_q));

  p_grant_state_r5: assert property (@(posedge clk) disable iff (rst)
    wrsr_grant_q |-> (st_q.busy && !st_q.wel));

  p_code_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wrsr_grant_q |-> $stable(st_q.code) && $stable(st_q.lock));

  p_bulk_refuse_r6: assert property (@(posedge clk) disable iff (rst)
    (mod_req && mod_cmd == CMD_BULK_ERASE && st_q.code != '0)
      |=> (!mod_grant_q && mod_prot_q));

  p_prot_wel_r7: assert property (@(posedge clk) disable iff (rst)
    (mod_req && !st_q.busy) ##1 mod_prot_q |-> !st_q.wel);

  p_mod_grant_r8: assert property (@(posedge clk) disable iff (rst)
    mod_grant_q |-> (st_q.busy && !st_q.wel));

  p_busy_deny_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q.busy && (wrsr_req || mod_req)) |=> (!wrsr_grant_q && !mod_grant_q));

endmodule

// File: rtl/sr_protect_unit.sv
module sr_protect_unit
  import sr_prot_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int SECT_W = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wp_n,
  input  logic                wren_req,
  input  logic                wrdi_req,
  input  logic                wrsr_req,
  input  logic [STATUS_W-1:0] wrsr_data,
  input  logic                mod_req,
  input  logic [1:0]          mod_cmd,
  input  logic [ADDR_W-1:0]   mod_addr,
  input  logic                op_done,
  output logic [STATUS_W-1:0] status,
  output logic                wrsr_grant,
  output logic                wrsr_deny,
  output logic                mod_grant,
  output logic                mod_deny,
  output logic                mod_protected
);

  localparam int OFFS_W = ADDR_W - SECT_W;

  status_t           st_q;
  mod_cmd_e          cmd;
  logic [SECT_W-1:0] sector;
  logic              in_region;
  logic              wrsr_ok;
  logic              mod_ok;
  logic              mod_hit;
  logic              drop_wel;
  logic              unused_offs;

  assign cmd         = mod_cmd_e'(mod_cmd);
  assign sector      = mod_addr[ADDR_W-1 -: SECT_W];
  assign unused_offs = ^mod_addr[OFFS_W-1:0];

  sr_region_map #(.SECT_W(SECT_W), .CODE_W(CODE_W)) u_map (
    .code      (st_q.code),
    .sector    (sector),
    .in_region (in_region)
  );

  sr_request_eval u_eval (
    .st        (st_q),
    .wp_n      (wp_n),
    .wrsr_req  (wrsr_req),
    .mod_req   (mod_req),
    .mod_cmd   (cmd),
    .in_region (in_region),
    .wrsr_ok   (wrsr_ok),
    .mod_ok    (mod_ok),
    .mod_hit   (mod_hit),
    .drop_wel  (drop_wel)
  );

  sr_status_core u_core (
    .clk          (clk),
    .rst          (rst),
    .wp_n         (wp_n),
    .wren_req     (wren_req),
    .wrdi_req     (wrdi_req),
    .wrsr_req     (wrsr_req),
    .wrsr_data    (wrsr_data),
    .mod_req      (mod_req),
    .mod_cmd      (cmd),
    .op_done      (op_done),
    .wrsr_ok      (wrsr_ok),
    .mod_ok       (mod_ok),
    .mod_hit      (mod_hit),
    .drop_wel     (drop_wel),
    .st_q         (st_q),
    .wrsr_grant_q (wrsr_grant),
    .wrsr_deny_q  (wrsr_deny),
    .mod_grant_q  (mod_grant),
    .mod_deny_q   (mod_deny),
    .mod_prot_q   (mod_protected)
  );

  assign status = st_q;

endmodule

// File: tb/sr_protect_unit_tb.sv
module sr_protect_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 21;
  localparam int SECT_W     = 5;
  localparam int NSECT      = 32;
  localparam int SECT_BYTES = 1 << (ADDR_W - SECT_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_n = 1'b1;
  logic wren_req = 1'b0, wrdi_req = 1'b0, wrsr_req = 1'b0, mod_req = 1'b0, op_done = 1'b0;
  logic [7:0] wrsr_data = '0;
  logic [1:0] mod_cmd = '0;
  logic [ADDR_W-1:0] mod_addr = '0;
  logic [7:0] status;
  logic wrsr_grant, wrsr_deny, mod_grant, mod_deny, mod_protected;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_protect_unit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dut (
    .clk(clk), .rst(rst), .wp_n(wp_n), .wren_req(wren_req), .wrdi_req(wrdi_req),
    .wrsr_req(wrsr_req), .wrsr_data(wrsr_data), .mod_req(mod_req), .mod_cmd(mod_cmd),
    .mod_addr(mod_addr), .op_done(op_done), .status(status), .wrsr_grant(wrsr_grant),
    .wrsr_deny(wrsr_deny), .mod_grant(mod_grant), .mod_deny(mod_deny),
    .mod_protected(mod_protected)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  // behavioural reference model
  int m_busy, m_wel, m_code, m_lock;
  int e_wg, e_wd, e_mg, e_md, e_mp;

  function automatic int sect_protected(int code, int sect);
    int n;
    if (code == 0) return 0;
    n = (code - 1 >= SECT_W) ? NSECT : (1 << (code - 1));
    return (sect >= NSECT - n) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int prot, wok, mok, locked;
    if (rst) begin
      m_busy = 0; m_wel = 0; m_code = 0; m_lock = 0;
      e_wg = 0; e_wd = 0; e_mg = 0; e_md = 0; e_mp = 0;
    end else begin
      locked = (m_lock == 1 && wp_n == 1'b0) ? 1 : 0;
      if (mod_cmd == 2'b10)      prot = (m_code != 0) ? 1 : 0;
      else if (mod_cmd == 2'b11) prot = 0;
      else prot = sect_protected(m_code, int'(mod_addr) / SECT_BYTES);
      wok = (wrsr_req && m_busy == 0 && m_wel == 1 && locked == 0) ? 1 : 0;
      mok = (mod_req && mod_cmd != 2'b11 && m_busy == 0 && m_wel == 1 && prot == 0) ? 1 : 0;
      e_wg = wok; e_wd = (wrsr_req && wok == 0) ? 1 : 0;
      e_mg = mok; e_md = (mod_req && mok == 0) ? 1 : 0;
      e_mp = (mod_req && prot == 1) ? 1 : 0;
      if (op_done) begin
        if (wok == 0 && mok == 0) m_busy = 0;
      end
      if (wok == 1) begin
        m_code = int'(wrsr_data[4:2]); m_lock = int'(wrsr_data[7]); m_wel = 0; m_busy = 1;
      end else if (mok == 1) begin
        m_wel = 0; m_busy = 1;
      end else if (mod_req && prot == 1 && m_busy == 0) begin
        m_wel = 0;
      end else if (wren_req && m_busy == 0) begin
        m_wel = 1;
      end else if (wrdi_req && m_busy == 0) begin
        m_wel = 0;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("status", int'(status), (m_lock << 7) | (m_code << 2) | (m_wel << 1) | m_busy);
      chk("wrsr_grant", int'(wrsr_grant), e_wg);
      chk("wrsr_deny", int'(wrsr_deny), e_wd);
      chk("mod_grant", int'(mod_grant), e_mg);
      chk("mod_deny", int'(mod_deny), e_md);
      chk("mod_protected", int'(mod_protected), e_mp);
    end
  end

  task automatic clear_in();
    wren_req = 0; wrdi_req = 0; wrsr_req = 0; mod_req = 0; op_done = 0;
  endtask
  task automatic step();
    @(negedge clk); clear_in();
  endtask
  task automatic t_wren(); wren_req = 1; step(); endtask
  task automatic t_wrdi(); wrdi_req = 1; step(); endtask
  task automatic t_done(); op_done = 1; step(); endtask
  task automatic t_wrsr(logic [7:0] d); wrsr_req = 1; wrsr_data = d; step(); endtask
  task automatic t_mod(logic [1:0] c, int a);
    mod_req = 1; mod_cmd = c; mod_addr = ADDR_W'(a); step();
  endtask
  task automatic set_status(int code, int lock);
    wp_n = 1; t_wren(); t_wrsr(8'((lock << 7) | (code << 2))); t_done();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(posedge clk); cmp_en = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    cur_tag = "R1";
    chk("reset status", int'(status), 0);
    chk("reset grants", int'({wrsr_grant, wrsr_deny, mod_grant, mod_deny, mod_protected}), 0);

    cur_tag = "R2";
    t_wren(); chk("wel set", int'(status[1]), 1);
    t_wrdi(); chk("wel clear", int'(status[1]), 0);

    cur_tag = "R8";
    t_mod(2'b00, 0);          // no write enable: denied
    t_wren(); t_mod(2'b11, 0);  // reserved code
    t_mod(2'b01, 5 * SECT_BYTES);
    chk("busy after erase", int'(status[0]), 1);

    cur_tag = "R9";
    t_wrsr(8'h9C); t_mod(2'b00, 0); t_wren(); t_wrdi();
    chk("readable while busy", int'(status), 1);
    t_done();

    cur_tag = "R3";
    for (int code = 0; code < 8; code++) begin
      set_status(code, 0);
      for (int s = 0; s < NSECT; s++) begin
        for (int k = 0; k < 2; k++) begin
          for (int c = 0; c < 2; c++) begin
            t_wren(); t_mod(2'(c), s * SECT_BYTES + k * (SECT_BYTES - 1)); t_done();
          end
        end
      end
      cur_tag = "R6";
      t_wren(); t_mod(2'b10, 0); t_done();
      t_wren(); t_mod(2'b00, (NSECT - 1) * SECT_BYTES);  // R7 top sector
      cur_tag = "R3";
      t_done();
    end

    cur_tag = "R4";
    for (int lk = 0; lk < 2; lk++) begin
      for (int pin = 0; pin < 2; pin++) begin
        set_status(1, lk);
        wp_n = 1'(pin);
        t_wren(); t_wrsr(8'h14); t_done();
        chk("lock truth table", int'(status[4:2]), (lk == 1 && pin == 0) ? 1 : 5);
      end
    end
    wp_n = 1;

    cur_tag = "R5";
    set_status(0, 0);
    t_wren(); t_wrsr(8'h63);
    chk("ignored data bits", int'(status), 8'h01);
    t_done();
    t_wrsr(8'h0C);  // write enable clear
    chk("no wel no write", int'(status[4:2]), 0);

    cur_tag = "R7";
    set_status(2, 0);
    t_wren(); t_mod(2'b01, 30 * SECT_BYTES);
    chk("wel dropped", int'(status[1]), 0);
    chk("protected pulse", int'(mod_protected), 1);

    cur_tag = "R10";
    t_wren(); t_mod(2'b00, 0);
    step();
    chk("single pulse", int'(mod_grant), 0);
    t_done();

    step();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule